// File: doc/BRIEF.md
# Exception Vector Dispatch Unit

This unit carries a simple processor core from normal execution into an exception handler and back. The core reports exceptions raised by the instruction it is running (system call, page fault, divide by zero, protection fault and similar) on a synchronous request vector. It reports events from outside the core on an asynchronous request vector, which the core presents only at an instruction boundary it has chosen. Each request bit is an exception type code, its index in the vector. When the unit is idle and any request is present, it picks one type and copies the current program counter and stack pointer into save registers. It switches the core to kernel mode and reads the handler pointer for that type from a table in memory. The table's location is held in a base register.

The handler pointer comes back through a single-beat memory read port. The unit then pulses a fetch redirect to that pointer. A return input, accepted only in kernel mode, sends fetch back to the saved program counter, hands back the saved stack pointer and drops to user mode, all in one cycle. The base register can be written only in kernel mode. A write attempted in user mode does not change the base and becomes a privilege exception of its own.

Top module: `exc_dispatch`

## Requirements
- R1: A request seen while `busy` is low is taken. On the next cycle `busy` and `kernel_mode` are 1, `saved_pc` equals the `cur_pc` of the request cycle, and `saved_sp` equals its `cur_sp`.
- R2: The type code is the bit index in the request vectors. Any synchronous request wins over all asynchronous ones. Within the chosen vector, the lowest set index wins.
- R3: `mem_rd_en` is high for exactly the one cycle after entry. In that cycle `mem_rd_addr` is the table base plus the type code times 8, so each table entry is a 64-bit pointer.
- R4: While waiting, a cycle with `mem_rd_valid` high ends the wait. On the next cycle `redirect_valid` pulses for one cycle with `redirect_pc` equal to `mem_rd_data`, and `busy` is low.
- R5: While `busy` is high, requests, `eret` and `cur_pc`/`cur_sp` are ignored. The saved registers do not change and `kernel_mode` stays 1.
- R6: `eret` in kernel mode while idle, with no request present, gives all of the following on the next cycle: `redirect_valid` with `redirect_pc` equal to `saved_pc`, `restore_sp_valid` with `restore_sp` equal to `saved_sp`, and `kernel_mode` 0.
- R7: `eret` in user mode has no effect: no redirect, and the mode stays user. `eret` in the same cycle as a request is dropped, and the request is taken.
- R8: A base write in kernel mode shows on `table_base` on the next cycle. An entry taken in the same cycle uses the old base.
- R9: A base write in user mode while idle leaves `table_base` unchanged. It raises a synchronous exception of type 13, which competes under R2 like any other synchronous request.
- R10: Reset (synchronous, active high) leaves `kernel_mode` 1, `busy` 0, and `table_base`, `saved_pc`, `saved_sp` all 0. It also leaves `mem_rd_en`, `redirect_valid` and `restore_sp_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 16 | Synchronous exception requests, one bit per type |
| async_req | input | 16 | Asynchronous exception requests, one bit per type |
| cur_pc | input | 64 | PC to save: faulting instruction, or next instruction at a boundary |
| cur_sp | input | 64 | Current stack pointer |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | 64 | New table base |
| eret | input | 1 | Return from exception |
| mem_rd_en | output | 1 | Table read request (one cycle) |
| mem_rd_addr | output | 64 | Table entry byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Handler pointer read from the table |
| busy | output | 1 | Dispatch in progress; the core must hold requests |
| kernel_mode | output | 1 | 1 = kernel, 0 = user |
| table_base | output | 64 | Current table base |
| saved_pc | output | 64 | Saved program counter |
| saved_sp | output | 64 | Saved stack pointer |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 64 | Fetch redirect target |
| restore_sp_valid | output | 1 | Stack pointer restore pulse |
| restore_sp | output | 64 | Stack pointer value to restore |

## Verification
The hardest case to reach is a user-mode base write that must turn into a privilege exception. The core is in kernel mode after reset, so the stimulus first writes a base while in kernel mode, then returns to drop into user mode. Only then does it write the base, once alone and once together with a lower-numbered synchronous request that must win. The other hard case is a request that arrives while a table read is still pending. The bench holds the memory response back and drives requests, returns and new PC values during the wait. It then shows that the saved state and the mode did not move.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN      = 64;
    localparam int TYPE_W    = 4;
    localparam int NTYPE     = 1 << TYPE_W;
    localparam int PTR_SHIFT = 3;   // 8-byte table entries

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } disp_state_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] sp;
    } ctx_t;

    typedef struct packed {
        logic              hit;
        logic [TYPE_W-1:0] code;
    } pick_t;

    function automatic logic [NTYPE-1:0] type_bit(input logic [TYPE_W-1:0] t);
        return NTYPE'(1) << t;
    endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] code
);
    always_comb begin
        hit  = 1'b0;
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit  = 1'b1;
                code = W'(i);
            end
        end
    end
endmodule

// File: rtl/exc_table_addr.sv
module exc_table_addr #(
    parameter int AW    = 64,
    parameter int TW    = 4,
    parameter int SHIFT = 3
) (
    input  logic [AW-1:0] base,
    input  logic [TW-1:0] code,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] offset;
    assign offset = {{(AW-TW){1'b0}}, code} << SHIFT;
    assign addr   = base + offset;
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_pkg::*;
#(
    parameter logic [TYPE_W-1:0] PRIV_TYPE = 4'd13,
    parameter logic [XLEN-1:0]   BASE_RST  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NTYPE-1:0]  sync_req,
    input  logic [NTYPE-1:0]  async_req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_sp,
    input  logic              base_wr_en,
    input  logic [XLEN-1:0]   base_wr_data,
    input  logic              eret,
    output logic              mem_rd_en,
    output logic [XLEN-1:0]   mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [XLEN-1:0]   mem_rd_data,
    output logic              busy,
    output logic              kernel_mode,
    output logic [XLEN-1:0]   table_base,
    output logic [XLEN-1:0]   saved_pc,
    output logic [XLEN-1:0]   saved_sp,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              restore_sp_valid,
    output logic [XLEN-1:0]   restore_sp
);
    disp_state_e     state_q;
    logic            kmode_q;
    logic [XLEN-1:0] base_q;
    ctx_t            ctx_q;
    logic [XLEN-1:0] rd_addr_q;
    logic            redir_v_q;
    logic [XLEN-1:0] redir_pc_q;
    logic            rsp_v_q;
    logic [XLEN-1:0] rsp_q;

    logic            idle;
    logic            priv_fault;
    logic [NTYPE-1:0] sync_eff;
    pick_t           pick_s, pick_a;
    logic            take;
    logic [TYPE_W-1:0] take_code;
    logic [XLEN-1:0] entry_addr;
    logic            do_ret;

    assign idle       = (state_q == ST_IDLE);
    assign priv_fault = idle && !kmode_q && base_wr_en;
    assign sync_eff   = sync_req | (priv_fault ? type_bit(PRIV_TYPE) : '0);

    exc_prio_pick #(.N(NTYPE), .W(TYPE_W)) u_pick_sync (
        .req (sync_eff),
        .hit (pick_s.hit),
        .code(pick_s.code)
    );

    exc_prio_pick #(.N(NTYPE), .W(TYPE_W)) u_pick_async (
        .req (async_req),
        .hit (pick_a.hit),
        .code(pick_a.code)
    );

    assign take      = idle && (pick_s.hit || pick_a.hit);
    assign take_code = pick_s.hit ? pick_s.code : pick_a.code;

    exc_table_addr #(.AW(XLEN), .TW(TYPE_W), .SHIFT(PTR_SHIFT)) u_addr (
        .base(base_q),
        .code(take_code),
        .addr(entry_addr)
    );

    assign do_ret = idle && kmode_q && eret && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            kmode_q    <= 1'b1;
            base_q     <= BASE_RST;
            ctx_q      <= '0;
            rd_addr_q  <= '0;
            redir_v_q  <= 1'b0;
            redir_pc_q <= '0;
            rsp_v_q    <= 1'b0;
            rsp_q      <= '0;
        end else begin
            redir_v_q <= 1'b0;
            rsp_v_q   <= 1'b0;
            if (kmode_q && base_wr_en) begin
                base_q <= base_wr_data;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        ctx_q     <= '{pc: cur_pc, sp: cur_sp};
                        kmode_q   <= 1'b1;
                        rd_addr_q <= entry_addr;
                        state_q   <= ST_REQ;
                    end else if (do_ret) begin
                        redir_v_q  <= 1'b1;
                        redir_pc_q <= ctx_q.pc;
                        rsp_v_q    <= 1'b1;
                        rsp_q      <= ctx_q.sp;
                        kmode_q    <= 1'b0;
                    end
                end
                ST_REQ: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        redir_v_q  <= 1'b1;
                        redir_pc_q <= mem_rd_data;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en        = (state_q == ST_REQ);
    assign mem_rd_addr      = rd_addr_q;
    assign busy             = !idle;
    assign kernel_mode      = kmode_q;
    assign table_base       = base_q;
    assign saved_pc         = ctx_q.pc;
    assign saved_sp         = ctx_q.sp;
    assign redirect_valid   = redir_v_q;
    assign redirect_pc      = redir_pc_q;
    assign restore_sp_valid = rsp_v_q;
    assign restore_sp       = rsp_q;
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
    import exc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NTYPE-1:0]  sync_req,
    input logic [NTYPE-1:0]  async_req,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   cur_sp,
    input logic              base_wr_en,
    input logic [XLEN-1:0]   base_wr_data,
    input logic              eret,
    input logic              mem_rd_en,
    input logic [XLEN-1:0]   mem_rd_addr,
    input logic              mem_rd_valid,
    input logic [XLEN-1:0]   mem_rd_data,
    input logic              busy,
    input logic              kernel_mode,
    input logic [XLEN-1:0]   table_base,
    input logic [XLEN-1:0]   saved_pc,
    input logic [XLEN-1:0]   saved_sp,
    input logic              redirect_valid,
    input logic [XLEN-1:0]   redirect_pc,
    input logic              restore_sp_valid,
    input logic [XLEN-1:0]   restore_sp
);
    a_r1_entry: assert property (@(posedge clk) disable iff (rst)
        (!busy && ((|sync_req) || (|async_req)))
        |=> (busy && kernel_mode && saved_pc == $past(cur_pc) && saved_sp == $past(cur_sp)));

    a_r3_type0_addr: assert property (@(posedge clk) disable iff (rst)
        (!busy && sync_req[0]) |=> (mem_rd_en && mem_rd_addr == $past(table_base)));

    a_r3_single_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    a_r4_redirect: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rd_en && mem_rd_valid)
        |=> (redirect_valid && redirect_pc == $past(mem_rd_data) && !busy));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(saved_pc) && $stable(saved_sp) && kernel_mode));

    a_r6_return: assert property (@(posedge clk) disable iff (rst)
        (!busy && kernel_mode && eret && !(|sync_req) && !(|async_req))
        |=> (!kernel_mode && redirect_valid && redirect_pc == $past(saved_pc)
             && restore_sp_valid && restore_sp == $past(saved_sp)));

    a_r7_user_return: assert property (@(posedge clk) disable iff (rst)
        (!busy && !kernel_mode && eret && !(|sync_req) && !(|async_req) && !base_wr_en)
        |=> (!redirect_valid && !kernel_mode));

    a_r8_base_write: assert property (@(posedge clk) disable iff (rst)
        (kernel_mode && base_wr_en) |=> (table_base == $past(base_wr_data)));

    a_r9_user_base: assert property (@(posedge clk) disable iff (rst)
        (!busy && !kernel_mode && base_wr_en)
        |=> ($stable(table_base) && kernel_mode && busy));
endmodule

bind exc_dispatch exc_dispatch_chk chk_i (.*);

// File: tb/exc_dispatch_tb_top.sv
`timescale 1ns/1ps
module exc_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] sync_req, async_req;
    logic [63:0] cur_pc, cur_sp, base_wr_data, mem_rd_data;
    logic        base_wr_en, eret, mem_rd_valid;
    logic        mem_rd_en, busy, kernel_mode, redirect_valid, restore_sp_valid;
    logic [63:0] mem_rd_addr, table_base, saved_pc, saved_sp, redirect_pc, restore_sp;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    exc_dispatch dut_i (
        .clk(clk), .rst(rst), .sync_req(sync_req), .async_req(async_req),
        .cur_pc(cur_pc), .cur_sp(cur_sp), .base_wr_en(base_wr_en),
        .base_wr_data(base_wr_data), .eret(eret), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .busy(busy), .kernel_mode(kernel_mode),
        .table_base(table_base), .saved_pc(saved_pc), .saved_sp(saved_sp),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .restore_sp_valid(restore_sp_valid), .restore_sp(restore_sp)
    );

    function automatic logic [63:0] handler_of(input logic [63:0] a);
        return a * 3 + 64'h4000;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_in();
        sync_req = '0; async_req = '0; base_wr_en = 1'b0; base_wr_data = '0;
        eret = 1'b0; mem_rd_valid = 1'b0; mem_rd_data = '0;
    endtask

    task automatic enter(input logic [15:0] s, input logic [15:0] a,
                         input logic [63:0] pc, input logic [63:0] sp, input string tag);
        sync_req = s; async_req = a; cur_pc = pc; cur_sp = sp;
        tick();
        clear_in();
        chk({tag, " R1 busy"}, 64'(busy), 64'd1);
        chk({tag, " R1 kernel"}, 64'(kernel_mode), 64'd1);
        chk({tag, " R1 saved_pc"}, saved_pc, pc);
        chk({tag, " R1 saved_sp"}, saved_sp, sp);
    endtask

    task automatic issue_check(input logic [63:0] addr, input string tag);
        chk({tag, " R3 rd_en"}, 64'(mem_rd_en), 64'd1);
        chk({tag, " R3 rd_addr"}, mem_rd_addr, addr);
        tick();
        chk({tag, " R3 rd_en one cycle"}, 64'(mem_rd_en), 64'd0);
    endtask

    task automatic finish_read(input logic [63:0] addr, input string tag);
        mem_rd_valid = 1'b1; mem_rd_data = handler_of(addr);
        tick();
        clear_in();
        chk({tag, " R4 redirect_valid"}, 64'(redirect_valid), 64'd1);
        chk({tag, " R4 redirect_pc"}, redirect_pc, handler_of(addr));
        chk({tag, " R4 busy low"}, 64'(busy), 64'd0);
        tick();
        chk({tag, " R4 pulse ends"}, 64'(redirect_valid), 64'd0);
    endtask

    task automatic do_eret(input logic [63:0] pc, input logic [63:0] sp, input string tag);
        eret = 1'b1;
        tick();
        eret = 1'b0;
        chk({tag, " R6 redirect_valid"}, 64'(redirect_valid), 64'd1);
        chk({tag, " R6 redirect_pc"}, redirect_pc, pc);
        chk({tag, " R6 restore_sp_valid"}, 64'(restore_sp_valid), 64'd1);
        chk({tag, " R6 restore_sp"}, restore_sp, sp);
        chk({tag, " R6 user mode"}, 64'(kernel_mode), 64'd0);
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; clear_in(); cur_pc = '0; cur_sp = '0;
        repeat (3) tick();
        chk("R10 kernel", 64'(kernel_mode), 64'd1);
        chk("R10 busy", 64'(busy), 64'd0);
        chk("R10 base", table_base, 64'd0);
        chk("R10 saved_pc", saved_pc, 64'd0);
        chk("R10 saved_sp", saved_sp, 64'd0);
        chk("R10 rd_en", 64'(mem_rd_en), 64'd0);
        chk("R10 redirect", 64'(redirect_valid), 64'd0);
        chk("R10 restore", 64'(restore_sp_valid), 64'd0);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_base_kernel();
        base_wr_en = 1'b1; base_wr_data = 64'h1000;
        tick();
        clear_in();
        chk("R8 kernel base write", table_base, 64'h1000);
    endtask

    task automatic t_boot_return();
        do_eret(64'd0, 64'd0, "boot return");
    endtask

    task automatic t_user_base();
        base_wr_en = 1'b1; base_wr_data = 64'hDEAD_0000;
        enter('0, '0, 64'h400, 64'h7F00, "R9 user base");
        chk("R9 base unchanged", table_base, 64'h1000);
        issue_check(64'h1000 + 13 * 8, "R9 priv type");
        finish_read(64'h1000 + 13 * 8, "R9 priv");
        do_eret(64'h400, 64'h7F00, "R9 return");
    endtask

    task automatic t_prio_sync();
        enter(16'h0A00, 16'h0004, 64'h500, 64'h7E00, "R2 sync over async");
        issue_check(64'h1000 + 9 * 8, "R2 type9");
        finish_read(64'h1000 + 9 * 8, "R2 sync");
        do_eret(64'h500, 64'h7E00, "R2 return");
    endtask

    task automatic t_async_hold();
        enter('0, 16'h0088, 64'h600, 64'h7D00, "R2 async lowest");
        issue_check(64'h1000 + 3 * 8, "R2 type3");
        for (int k = 0; k < 3; k++) begin
            sync_req = 16'h0001; eret = 1'b1; cur_pc = 64'hBAD0 + 64'(k); cur_sp = 64'hBAD8;
            tick();
            chk("R5 still busy", 64'(busy), 64'd1);
            chk("R5 no read", 64'(mem_rd_en), 64'd0);
            chk("R5 saved_pc held", saved_pc, 64'h600);
            chk("R5 saved_sp held", saved_sp, 64'h7D00);
            chk("R5 kernel", 64'(kernel_mode), 64'd1);
        end
        clear_in();
        finish_read(64'h1000 + 3 * 8, "R5 async");
        chk("R5 saved_pc after", saved_pc, 64'h600);
        do_eret(64'h600, 64'h7D00, "R5 return");
    endtask

    task automatic t_user_eret();
        eret = 1'b1;
        tick();
        eret = 1'b0;
        chk("R7 user eret no redirect", 64'(redirect_valid), 64'd0);
        chk("R7 user eret stays user", 64'(kernel_mode), 64'd0);
        chk("R7 user eret not busy", 64'(busy), 64'd0);
    endtask

    task automatic t_eret_vs_req();
        enter(16'h0002, '0, 64'h700, 64'h7C00, "R7 setup");
        issue_check(64'h1000 + 8, "R7 setup type1");
        finish_read(64'h1000 + 8, "R7 setup");
        eret = 1'b1;
        enter('0, 16'h0010, 64'h710, 64'h7C10, "R7 eret plus req");
        chk("R7 no return redirect", 64'(redirect_valid), 64'd0);
        issue_check(64'h1000 + 4 * 8, "R7 type4");
        finish_read(64'h1000 + 4 * 8, "R7 nested");
    endtask

    task automatic t_base_during_entry();
        base_wr_en = 1'b1; base_wr_data = 64'h2000;
        enter(16'h0020, '0, 64'h800, 64'h7B00, "R8 write with entry");
        chk("R8 new base visible", table_base, 64'h2000);
        issue_check(64'h1000 + 5 * 8, "R8 old base used");
        finish_read(64'h1000 + 5 * 8, "R8");
        do_eret(64'h800, 64'h7B00, "R8 return");
    endtask

    task automatic t_priv_vs_lower();
        base_wr_en = 1'b1; base_wr_data = 64'h3000;
        enter(16'h0004, '0, 64'h900, 64'h7A00, "R9 priv vs type2");
        chk("R9 base kept", table_base, 64'h2000);
        issue_check(64'h2000 + 2 * 8, "R9 type2 wins");
        finish_read(64'h2000 + 2 * 8, "R9 lower");
        do_eret(64'h900, 64'h7A00, "R9 return2");
    endtask

    initial begin
        t_reset();
        t_base_kernel();
        t_boot_return();
        t_user_base();
        t_prio_sync();
        t_async_hold();
        t_user_eret();
        t_eret_vs_req();
        t_base_during_entry();
        t_priv_vs_lower();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule